// File: doc/BRIEF.md
# Multi-Source Broadcast Receive Buffer

This block is the receive end of a broadcast fabric in which every remote sender owns a dedicated channel and every receiver observes every transmission. Each channel presents a valid strobe, a 32-bit data word and a 4-bit message-type tag. Because no two senders share a channel, any number of them may deliver in the same cycle. The block keeps one small FIFO per sender, so all of those words are enqueued together with no arbitration.

Software sets up two filters through a configuration port. The first is a per-sender enable mask and the second is a per-type enable mask. An arriving word is queued only when both masks accept it. Accepted words stay in their sender's queue until the local core reads them. The core selects a queue by sender index, sees that queue's head word and type, and pops it with a strobe. A bitmap of non-empty queues helps the core pick the next sender to serve. A per-sender sticky flag records any word lost to a full queue.

Top module: `bcast_rx_buffer`

## Requirements
- R1: Each sender index has its own queue of 4 entries holding a 32-bit word and its 4-bit type. Words arriving from any set of senders in one cycle are all enqueued in that cycle.
- R2: A word from sender i is queued only when bit i of the sender-enable mask is 1.
- R3: A word with type t is queued only when bit t of the 16-bit type-enable mask is 1.
- R4: A queue returns words in arrival order. `rd_data`/`rd_type` show the head of the queue chosen by `rd_sel`, and `rd_pop` removes it. Other queues are untouched.
- R5: When the selected queue is empty, `rd_empty` is 1 and a pop is ignored. A pop and an arrival on an empty queue in the same cycle leave the new word queued.
- R6: A word that arrives at a full queue with no pop of that queue in the same cycle is dropped. The queue contents are unchanged, and `overflow_map[i]` is set and held.
- R7: A configuration write (`cfg_we`) loads both masks, which govern arrivals from the next cycle on, and clears every overflow bit. An overflow occurring in the write cycle still sets its bit.
- R8: When a queue is full and a pop and an arrival hit it in the same cycle, both take effect. The new word takes the freed slot and no overflow is flagged.
- R9: `nonempty_map[i]` is 1 exactly when queue i holds at least one word. It updates in the cycle after the arrival or pop.
- R10: After reset all queues are empty, all overflow bits are 0, and both masks are 0, so every arrival is rejected until a configuration write.
- R11: An `rd_sel` value of `NUM_SRC` or above selects no queue. `rd_empty` is 1, `rd_data` and `rd_type` are 0, and a pop changes no queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_SRC | Per-sender arrival strobe |
| in_data | input | NUM_SRC*32 | Per-sender word; sender i at bits [32i+31:32i] |
| in_type | input | NUM_SRC*4 | Per-sender type tag; sender i at bits [4i+3:4i] |
| cfg_we | input | 1 | Loads both masks and clears overflow bits |
| cfg_src_mask | input | NUM_SRC | Sender-enable mask, bit i for sender i |
| cfg_type_mask | input | 16 | Type-enable mask, bit t for type t |
| rd_sel | input | SEL_W | Sender index of the queue being read |
| rd_pop | input | 1 | Removes the head of the selected queue |
| rd_data | output | 32 | Head word of the selected queue |
| rd_type | output | 4 | Head type of the selected queue |
| rd_empty | output | 1 | Selected queue is empty or index is out of range |
| nonempty_map | output | NUM_SRC | Bit i set when queue i holds words |
| overflow_map | output | NUM_SRC | Sticky per-sender drop flags |

## Verification
The hardest case to reach from the ports is a full queue that receives a new word and a pop in the same cycle. The FIFO must free the slot and refill it in one step without raising the drop flag. To reach it, the bench fills one sender's queue with four separate arrivals. It then drives a fifth arrival and a pop of that sender together, and drains the queue to confirm the final order. A second hard case is the window in which a configuration write and arrivals coincide. The bench times a mask change to land on the same edge as an arrival to show that the old mask still applies to that arrival.

// File: rtl/bcast_rx_pkg.sv
package bcast_rx_pkg;
  localparam int DATA_W_DEF     = 32;
  localparam int TYPE_W_DEF     = 4;
  localparam int QUEUE_DEPTH_DEF = 4;
  localparam int NUM_SRC_DEF    = 63;

  function automatic int sel_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rx_accept_filter.sv
module rx_accept_filter #(
  parameter int NUM_SRC = 63,
  parameter int TYPE_W  = 4,
  localparam int NTYPES = 1 << TYPE_W
) (
  input  logic [NUM_SRC-1:0]        arr_valid,
  input  logic [NUM_SRC*TYPE_W-1:0] arr_type,
  input  logic [NUM_SRC-1:0]        src_enable,
  input  logic [NTYPES-1:0]         type_enable,
  output logic [NUM_SRC-1:0]        accept
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [TYPE_W-1:0] t;
    assign t = arr_type[i*TYPE_W +: TYPE_W];
    assign accept[i] = arr_valid[i] & src_enable[i] & type_enable[t];
  end
endmodule

// File: rtl/rx_src_fifo.sv
module rx_src_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH < 2) ? 1 : $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         drop_evt
);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full, pop_ok, push_ok;

  assign empty    = (count == '0);
  assign full     = (count == FULL_CNT);
  assign pop_ok   = pop & ~empty;
  assign push_ok  = push & (~full | pop_ok);
  assign drop_evt = push & full & ~pop_ok;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rx_read_port.sv
module rx_read_port #(
  parameter int NUM_SRC = 63,
  parameter int W       = 36,
  parameter int SEL_W   = 6
) (
  input  logic [NUM_SRC*W-1:0] heads,
  input  logic [NUM_SRC-1:0]   empties,
  input  logic [SEL_W-1:0]     sel,
  input  logic                 pop,
  output logic [W-1:0]         head_out,
  output logic                 empty_out,
  output logic [NUM_SRC-1:0]   pop_vec
);
  localparam logic [SEL_W-1:0] LAST_SRC = SEL_W'(NUM_SRC - 1);
  logic in_range;
  assign in_range = (sel <= LAST_SRC);

  always_comb begin
    head_out  = '0;
    empty_out = 1'b1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (in_range && sel == SEL_W'(i)) begin
        head_out  = empties[i] ? '0 : heads[i*W +: W];
        empty_out = empties[i];
      end
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pop
    assign pop_vec[i] = pop & in_range & (sel == SEL_W'(i));
  end
endmodule

// File: rtl/bcast_rx_buffer.sv
module bcast_rx_buffer
  import bcast_rx_pkg::*;
#(
  parameter int NUM_SRC     = NUM_SRC_DEF,
  parameter int DATA_W      = DATA_W_DEF,
  parameter int TYPE_W      = TYPE_W_DEF,
  parameter int QUEUE_DEPTH = QUEUE_DEPTH_DEF,
  localparam int SEL_W      = sel_width(NUM_SRC),
  localparam int NTYPES     = 1 << TYPE_W,
  localparam int ENT_W      = DATA_W + TYPE_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        in_valid,
  input  logic [NUM_SRC*DATA_W-1:0] in_data,
  input  logic [NUM_SRC*TYPE_W-1:0] in_type,
  input  logic                      cfg_we,
  input  logic [NUM_SRC-1:0]        cfg_src_mask,
  input  logic [NTYPES-1:0]         cfg_type_mask,
  input  logic [SEL_W-1:0]          rd_sel,
  input  logic                      rd_pop,
  output logic [DATA_W-1:0]         rd_data,
  output logic [TYPE_W-1:0]         rd_type,
  output logic                      rd_empty,
  output logic [NUM_SRC-1:0]        nonempty_map,
  output logic [NUM_SRC-1:0]        overflow_map
);
  logic [NUM_SRC-1:0]       src_mask_q;
  logic [NTYPES-1:0]        type_mask_q;
  logic [NUM_SRC-1:0]       ovf_q;
  logic [NUM_SRC-1:0]       accept, empties, drops, pops;
  logic [NUM_SRC*ENT_W-1:0] heads;
  logic [ENT_W-1:0]         sel_head;

  rx_accept_filter #(.NUM_SRC(NUM_SRC), .TYPE_W(TYPE_W)) u_filter (
    .arr_valid   (in_valid),
    .arr_type    (in_type),
    .src_enable  (src_mask_q),
    .type_enable (type_mask_q),
    .accept      (accept)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_q
    rx_src_fifo #(.W(ENT_W), .DEPTH(QUEUE_DEPTH)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .push     (accept[i]),
      .pop      (pops[i]),
      .wdata    ({in_type[i*TYPE_W +: TYPE_W], in_data[i*DATA_W +: DATA_W]}),
      .head     (heads[i*ENT_W +: ENT_W]),
      .empty    (empties[i]),
      .drop_evt (drops[i])
    );
  end

  rx_read_port #(.NUM_SRC(NUM_SRC), .W(ENT_W), .SEL_W(SEL_W)) u_rd (
    .heads     (heads),
    .empties   (empties),
    .sel       (rd_sel),
    .pop       (rd_pop),
    .head_out  (sel_head),
    .empty_out (rd_empty),
    .pop_vec   (pops)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_mask_q  <= '0;
      type_mask_q <= '0;
      ovf_q       <= '0;
    end else begin
      if (cfg_we) begin
        src_mask_q  <= cfg_src_mask;
        type_mask_q <= cfg_type_mask;
        ovf_q       <= drops;
      end else begin
        ovf_q       <= ovf_q | drops;
      end
    end
  end

  assign rd_data      = sel_head[DATA_W-1:0];
  assign rd_type      = sel_head[ENT_W-1:DATA_W];
  assign nonempty_map = ~empties;
  assign overflow_map = ovf_q;
endmodule

// File: rtl/bcast_rx_checker.sv
module bcast_rx_checker #(
  parameter int NUM_SRC = 63,
  parameter int DATA_W  = 32,
  parameter int SEL_W   = 6
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] in_valid,
  input logic               cfg_we,
  input logic [SEL_W-1:0]   rd_sel,
  input logic [DATA_W-1:0]  rd_data,
  input logic               rd_empty,
  input logic [NUM_SRC-1:0] nonempty_map,
  input logic [NUM_SRC-1:0] overflow_map,
  input logic [NUM_SRC-1:0] src_mask_q
);
  localparam logic [SEL_W-1:0] LAST_SRC = SEL_W'(NUM_SRC - 1);

  assert_reset_clean_R10: assert property (@(posedge clk)
    rst |=> (nonempty_map == '0 && overflow_map == '0));

  assert_sticky_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ((overflow_map & $past(overflow_map)) == $past(overflow_map)));

  assert_cfg_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && in_valid == '0) |=> (overflow_map == '0));

  assert_src_blocked_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((nonempty_map & ~$past(nonempty_map) & ~$past(src_mask_q)) == '0));

  assert_fill_needs_arrival_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((nonempty_map & ~$past(nonempty_map) & ~$past(in_valid)) == '0));

  assert_empty_matches_map_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_sel <= LAST_SRC) |-> (rd_empty == !nonempty_map[rd_sel]));

  assert_bad_sel_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_sel > LAST_SRC) |-> (rd_empty && rd_data == '0));
endmodule

bind bcast_rx_buffer bcast_rx_checker #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .SEL_W(SEL_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .cfg_we       (cfg_we),
  .rd_sel       (rd_sel),
  .rd_data      (rd_data),
  .rd_empty     (rd_empty),
  .nonempty_map (nonempty_map),
  .overflow_map (overflow_map),
  .src_mask_q   (src_mask_q)
);

// File: tb/bcast_rx_buffer_test.sv
module bcast_rx_buffer_test;
  localparam int NS = 63;
  localparam int SW = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NS-1:0]   in_valid = '0;
  logic [NS*32-1:0] in_data = '0;
  logic [NS*4-1:0] in_type = '0;
  logic            cfg_we = 1'b0;
  logic [NS-1:0]   cfg_src_mask = '0;
  logic [15:0]     cfg_type_mask = '0;
  logic [SW-1:0]   rd_sel = '0;
  logic            rd_pop = 1'b0;
  logic [31:0]     rd_data;
  logic [3:0]      rd_type;
  logic            rd_empty;
  logic [NS-1:0]   nonempty_map, overflow_map;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bcast_rx_buffer uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_type(in_type),
    .cfg_we(cfg_we), .cfg_src_mask(cfg_src_mask), .cfg_type_mask(cfg_type_mask),
    .rd_sel(rd_sel), .rd_pop(rd_pop), .rd_data(rd_data), .rd_type(rd_type),
    .rd_empty(rd_empty), .nonempty_map(nonempty_map), .overflow_map(overflow_map)
  );

  function automatic logic [31:0] word_of(input int s, input int tag);
    return {8'hD5, 8'(tag), 8'h3C, 8'(s)};
  endfunction

  function automatic logic [3:0] type_of(input int s, input int tag);
    return 4'(s + tag);
  endfunction

  function automatic logic [NS-1:0] one_hot(input int s);
    logic [NS-1:0] v;
    v = '0;
    v[s] = 1'b1;
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock: drive at a falling edge, let the rising edge act, release at next falling edge.
  task automatic cyc(input logic [NS-1:0] v, input int tag, input logic pop, input int sel);
    in_valid = v;
    for (int s = 0; s < NS; s++) begin
      in_data[s*32 +: 32] = word_of(s, tag);
      in_type[s*4 +: 4]   = type_of(s, tag);
    end
    rd_pop = pop;
    rd_sel = SW'(sel);
    @(negedge clk);
    in_valid = '0;
    rd_pop   = 1'b0;
  endtask

  task automatic configure(input logic [NS-1:0] sm, input logic [15:0] tm);
    cfg_we = 1'b1;
    cfg_src_mask = sm;
    cfg_type_mask = tm;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic expect_head(input string req, input int s, input int tag);
    rd_sel = SW'(s);
    #1;
    check(req, {63'd0, rd_empty}, 64'd0);
    check(req, {32'd0, rd_data}, {32'd0, word_of(s, tag)});
    check(req, {60'd0, rd_type}, {60'd0, type_of(s, tag)});
  endtask

  task automatic pop_head(input string req, input int s, input int tag);
    expect_head(req, s, tag);
    cyc('0, 0, 1'b1, s);
  endtask

  task automatic t_reset;
    check("R10 nonempty after reset", {1'b0, nonempty_map}, 64'd0);
    check("R10 overflow after reset", {1'b0, overflow_map}, 64'd0);
    rd_sel = '0; #1;
    check("R10 empty after reset", {63'd0, rd_empty}, 64'd1);
    cyc('1, 1, 1'b0, 0);
    check("R10 zero masks reject", {1'b0, nonempty_map}, 64'd0);
  endtask

  task automatic t_src_filter;
    configure(one_hot(2) | one_hot(3), 16'hFFFF);
    cyc(one_hot(1) | one_hot(2) | one_hot(3), 4, 1'b0, 0);
    check("R2 sender mask", {1'b0, nonempty_map}, {1'b0, one_hot(2) | one_hot(3)});
    pop_head("R2 head s2", 2, 4);
    pop_head("R2 head s3", 3, 4);
    check("R9 drained", {1'b0, nonempty_map}, 64'd0);
  endtask

  task automatic t_type_filter;
    // tag 11 gives types 5,6,7 for senders 10,11,12; mask keeps types 5 and 7
    configure('1, 16'h00A0);
    cyc(one_hot(10) | one_hot(11) | one_hot(12), 11, 1'b0, 0);
    check("R3 type mask", {1'b0, nonempty_map}, {1'b0, one_hot(10) | one_hot(12)});
    pop_head("R3 head s10", 10, 11);
    pop_head("R3 head s12", 12, 11);
  endtask

  task automatic t_all_at_once;
    configure('1, 16'hFFFF);
    cyc('1, 7, 1'b0, 0);
    check("R1 all senders enqueued", {1'b0, nonempty_map}, {1'b0, {NS{1'b1}}});
    for (int s = 0; s < NS; s++) pop_head("R1 per-sender word", s, 7);
    check("R9 all drained", {1'b0, nonempty_map}, 64'd0);
  endtask

  task automatic t_order;
    cyc(one_hot(20) | one_hot(21), 1, 1'b0, 0);
    cyc(one_hot(20), 2, 1'b0, 0);
    cyc(one_hot(20), 3, 1'b0, 0);
    pop_head("R4 order 1", 20, 1);
    pop_head("R4 order 2", 20, 2);
    expect_head("R4 other queue intact", 21, 1);
    pop_head("R4 order 3", 20, 3);
    check("R9 s20 empty s21 full", {1'b0, nonempty_map}, {1'b0, one_hot(21)});
    pop_head("R4 s21", 21, 1);
  endtask

  task automatic t_empty_pop;
    cyc('0, 0, 1'b1, 30);
    rd_sel = SW'(30); #1;
    check("R5 empty flag", {63'd0, rd_empty}, 64'd1);
    check("R5 pop on empty ignored", {1'b0, nonempty_map}, 64'd0);
    cyc(one_hot(30), 9, 1'b1, 30);
    check("R5 push survives pop on empty", {1'b0, nonempty_map}, {1'b0, one_hot(30)});
    pop_head("R5 word kept", 30, 9);
  endtask

  task automatic t_overflow;
    for (int k = 1; k <= 4; k++) cyc(one_hot(5), k, 1'b0, 0);
    check("R6 no overflow at full", {1'b0, overflow_map}, 64'd0);
    cyc(one_hot(5), 5, 1'b0, 0);
    check("R6 overflow flagged", {1'b0, overflow_map}, {1'b0, one_hot(5)});
    cyc('0, 0, 1'b0, 0);
    check("R6 overflow sticky", {1'b0, overflow_map}, {1'b0, one_hot(5)});
    for (int k = 1; k <= 4; k++) pop_head("R6 contents kept", 5, k);
    rd_sel = SW'(5); #1;
    check("R6 fifth word dropped", {63'd0, rd_empty}, 64'd1);
    configure('1, 16'hFFFF);
    check("R7 cfg clears overflow", {1'b0, overflow_map}, 64'd0);
  endtask

  task automatic t_full_push_pop;
    for (int k = 1; k <= 4; k++) cyc(one_hot(7), k, 1'b0, 0);
    cyc(one_hot(7), 5, 1'b1, 7);
    check("R8 no overflow on push+pop", {1'b0, overflow_map}, 64'd0);
    for (int k = 2; k <= 5; k++) pop_head("R8 order after swap", 7, k);
    rd_sel = SW'(7); #1;
    check("R8 empty at end", {63'd0, rd_empty}, 64'd1);
  endtask

  task automatic t_cfg_timing;
    cfg_we = 1'b1;
    cfg_src_mask = '0;
    cfg_type_mask = 16'hFFFF;
    cyc(one_hot(40), 2, 1'b0, 0);
    cfg_we = 1'b0;
    check("R7 old mask applies in write cycle", {1'b0, nonempty_map}, {1'b0, one_hot(40)});
    cyc(one_hot(41), 2, 1'b0, 0);
    check("R7 new mask applies next", {1'b0, nonempty_map}, {1'b0, one_hot(40)});
    configure('1, 16'hFFFF);
    pop_head("R7 word from write cycle", 40, 2);
  endtask

  task automatic t_bad_sel;
    cyc(one_hot(0) | one_hot(62), 6, 1'b0, 0);
    rd_sel = SW'(63); #1;
    check("R11 out-of-range empty", {63'd0, rd_empty}, 64'd1);
    check("R11 out-of-range data", {32'd0, rd_data}, 64'd0);
    check("R11 out-of-range type", {60'd0, rd_type}, 64'd0);
    cyc('0, 0, 1'b1, 63);
    check("R11 pop changes nothing", {1'b0, nonempty_map}, {1'b0, one_hot(0) | one_hot(62)});
    pop_head("R11 s0 intact", 0, 6);
    pop_head("R11 s62 intact", 62, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_src_filter();
    t_type_filter();
    t_all_at_once();
    t_order();
    t_empty_pop();
    t_overflow();
    t_full_push_pop();
    t_cfg_timing();
    t_bad_sel();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule